// File: doc/BRIEF.md
# Dual-Window GPIO Controller with Level Interrupts

This block manages 24 general purpose pins through one 32-bit register bus that exposes two register windows. The privileged window reads every pin and configures any pin it still owns. The secondary window sees only the pins that the privileged side has handed over through a per-pin owner register. There is one copy of all pin configuration: output value, direction, interrupt enable, trigger level, sticky interrupt flag and interrupt mask. The owner register decides which window may change each bit of that copy. The windows never hold separate copies.

Pin inputs pass through a two-flop synchroniser. A flag is level-triggered: it sets while an enabled pin sits at its programmed level. It can only be cleared by writing a one once the pin has left that level. Each window has its own interrupt line. Each line collects the masked flags of the pins that window owns. A read-only mirror register keeps a snapshot of the pins taken just after reset.

Requests use a valid/ready handshake. `bus_ready` is held high, so every request is accepted on the clock edge where `bus_valid` is high, and there is no back-pressure. A read returns `rsp_valid` with its data one cycle after it is accepted. The response side cannot stall, so the requester must take the data in that cycle. Writes produce no response.

Top module: `dual_window_gpio`

## Requirements
- R1: Only data bits 23:0 exist. Read data bits 31:24 are always zero, and writes to those bits are ignored.
- R2: `pin_oe` equals the direction register. `pin_out` carries the output register on pins whose direction bit is 1 and is 0 on pins whose direction bit is 0.
- R3: A flag bit becomes 1 on any clock edge where its enable bit is 1 and its synchronised pin equals its level bit. Level 1 means active high and level 0 means active low. A pin change reaches the flags on the third rising edge after it is applied. Disabled pins never set flags.
- R4: Writing a 1 to a flag bit clears it. The write has no effect while that pin is still active, so the flag stays 1 until the pin or its level bit changes.
- R5: `irq_priv` is the OR over all bits of mask & flag & ~owner. `irq_sec` is the OR over all bits of mask & flag & owner.
- R6: When a pin's owner bit is 1, privileged writes to that bit of out, dir, enable, level, flag and mask are ignored. Privileged reads still return the bit.
- R7: Changing an owner bit makes the existing configuration of that pin visible through the other window, and moves its interrupt to the other line, on the next cycle.
- R8: Secondary-window reads return 0 for pins whose owner bit is 0. Secondary writes to those bits are dropped.
- R9: Word offsets on bus_addr[5:0]. Secondary window: 0x00 out, 0x04 dir, 0x08 in, 0x0C level, 0x10 flag, 0x14 mask, 0x18 mirror. Privileged window: 0x1C enable, 0x20 out, 0x24 dir, 0x28 in, 0x2C level, 0x30 flag, 0x34 mask, 0x38 mirror, 0x3C owner. In and mirror ignore writes. An address with nonzero bits 1:0 reads zero and ignores writes. Read data arrives with `rsp_valid` one cycle after acceptance.
- R10: The mirror register captures the synchronised pins once, on the third rising edge after reset is released, and keeps that value afterwards.
- R11: After reset every register is zero. All pins are owned by the privileged window and act as inputs, and both interrupt lines are low.
- R12: The in register returns the pins as they were two rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | 24 | Pin input levels |
| pin_out | output | 24 | Pin drive values |
| pin_oe | output | 24 | Pin output enables |
| irq_priv | output | 1 | Privileged-window interrupt |
| irq_sec | output | 1 | Secondary-window interrupt |

## Verification
The assertions assume that `bus_valid` is low during reset. The owned-bit write check also assumes a write request is not followed by an owner change in the same cycle, which the bus rules out by carrying one request per cycle. The bench drives every request and every pin change at the falling clock edge and holds `bus_valid` low during reset. Before it reads a flag or interrupt, it waits for the synchroniser latency.

// File: rtl/dwg_pkg.sv
package dwg_pkg;
  localparam int PIN_W  = 24;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;

  typedef enum logic [2:0] {
    FLD_OUT  = 3'd0,
    FLD_DIR  = 3'd1,
    FLD_IN   = 3'd2,
    FLD_LVL  = 3'd3,
    FLD_FLAG = 3'd4,
    FLD_MASK = 3'd5,
    FLD_MIR  = 3'd6,
    FLD_NONE = 3'd7
  } field_e;

  typedef struct packed {
    logic   hit;
    logic   sec;
    logic   is_en;
    logic   is_own;
    field_e fld;
  } dec_t;
endpackage

// File: rtl/dwg_sync.sv
module dwg_sync #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dwg_decode.sv
module dwg_decode
  import dwg_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic [AW-1:0] addr,
  output dec_t          dec
);
  localparam int IDX_W = AW - 2;
  localparam int SEC_LAST = 6;
  localparam int EN_IDX = 7;
  localparam int OWN_IDX = 15;

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx        = addr[AW-1:2];
    dec        = '0;
    dec.fld    = FLD_NONE;
    dec.hit    = (addr[1:0] == 2'b00);
    dec.sec    = (int'(idx) <= SEC_LAST);
    dec.is_en  = dec.hit && (int'(idx) == EN_IDX);
    dec.is_own = dec.hit && (int'(idx) == OWN_IDX);
    if (dec.hit) begin
      if (dec.sec) begin
        dec.fld = field_e'(idx[2:0]);
      end else if (int'(idx) > EN_IDX && int'(idx) < OWN_IDX) begin
        dec.fld = field_e'(idx[2:0]);
      end
    end
  end
endmodule

// File: rtl/dwg_store.sv
module dwg_store
  import dwg_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  dec_t         dec,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] sync_in,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] lvl_q,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] own_q,
  output logic [W-1:0] mir_q
);
  localparam int FILL = 2;

  logic [W-1:0] wmask;
  logic [W-1:0] clr;
  logic [W-1:0] active;
  logic [W-1:0] flag_d;
  logic         wr_hit;
  logic [1:0]   fill_cnt;
  logic         mir_done;

  assign wr_hit = wr && dec.hit;
  assign wmask  = dec.sec ? own_q : ~own_q;
  assign clr    = (wr_hit && dec.fld == FLD_FLAG) ? (wdata & wmask) : '0;

  for (genvar i = 0; i < W; i++) begin : g_flag
    assign active[i] = en_q[i] && (sync_in[i] == lvl_q[i]);
    assign flag_d[i] = active[i] | (flag_q[i] & ~clr[i]);
  end

  function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw,
                                         input logic [W-1:0] m);
    return (old & ~m) | (nw & m);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      en_q   <= '0;
      lvl_q  <= '0;
      flag_q <= '0;
      mask_q <= '0;
      own_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (wr_hit) begin
        if (dec.fld == FLD_OUT)  out_q  <= merge(out_q, wdata, wmask);
        if (dec.fld == FLD_DIR)  dir_q  <= merge(dir_q, wdata, wmask);
        if (dec.fld == FLD_LVL)  lvl_q  <= merge(lvl_q, wdata, wmask);
        if (dec.fld == FLD_MASK) mask_q <= merge(mask_q, wdata, wmask);
        if (dec.is_en)           en_q   <= merge(en_q, wdata, wmask);
        if (dec.is_own)          own_q  <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mir_q    <= '0;
      fill_cnt <= '0;
      mir_done <= 1'b0;
    end else if (!mir_done) begin
      if (int'(fill_cnt) == FILL) begin
        mir_q    <= sync_in;
        mir_done <= 1'b1;
      end else begin
        fill_cnt <= fill_cnt + 2'd1;
      end
    end
  end
endmodule

// File: rtl/dwg_readmux.sv
module dwg_readmux
  import dwg_pkg::*;
#(
  parameter int W  = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  dec_t          dec,
  input  logic [W-1:0]  sync_in,
  input  logic [W-1:0]  out_q,
  input  logic [W-1:0]  dir_q,
  input  logic [W-1:0]  en_q,
  input  logic [W-1:0]  lvl_q,
  input  logic [W-1:0]  flag_q,
  input  logic [W-1:0]  mask_q,
  input  logic [W-1:0]  own_q,
  input  logic [W-1:0]  mir_q,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  logic [W-1:0] sel;
  logic [W-1:0] view;

  always_comb begin
    sel = '0;
    unique case (dec.fld)
      FLD_OUT:  sel = out_q;
      FLD_DIR:  sel = dir_q;
      FLD_IN:   sel = sync_in;
      FLD_LVL:  sel = lvl_q;
      FLD_FLAG: sel = flag_q;
      FLD_MASK: sel = mask_q;
      FLD_MIR:  sel = mir_q;
      default: begin
        if (dec.is_en)  sel = en_q;
        if (dec.is_own) sel = own_q;
      end
    endcase
    if (!dec.hit) sel = '0;
    view = dec.sec ? (sel & own_q) : sel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= {{(DW-W){1'b0}}, view};
    end
  end
endmodule

// File: rtl/dual_window_gpio.sv
module dual_window_gpio
  import dwg_pkg::*;
#(
  parameter int PINS  = PIN_W,
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  output logic            bus_ready,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic            irq_priv,
  output logic            irq_sec
);
  dec_t            dec;
  logic [PINS-1:0] sync_q;
  logic [PINS-1:0] s_out, s_dir, s_en, s_lvl, s_flag, s_mask, s_own, s_mir;
  logic [DW-1:0]   unused_hi;

  assign bus_ready = 1'b1;
  assign unused_hi = bus_wdata;

  dwg_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
  );

  dwg_decode #(.AW(AW)) u_dec (
    .addr(bus_addr), .dec(dec)
  );

  dwg_store #(.W(PINS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr(bus_valid && bus_write), .dec(dec), .wdata(unused_hi[PINS-1:0]),
    .sync_in(sync_q),
    .out_q(s_out), .dir_q(s_dir), .en_q(s_en), .lvl_q(s_lvl),
    .flag_q(s_flag), .mask_q(s_mask), .own_q(s_own), .mir_q(s_mir)
  );

  dwg_readmux #(.W(PINS), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_valid && !bus_write), .dec(dec),
    .sync_in(sync_q),
    .out_q(s_out), .dir_q(s_dir), .en_q(s_en), .lvl_q(s_lvl),
    .flag_q(s_flag), .mask_q(s_mask), .own_q(s_own), .mir_q(s_mir),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign pin_oe   = s_dir;
  assign pin_out  = s_out & s_dir;
  assign irq_priv = |(s_mask & s_flag & ~s_own);
  assign irq_sec  = |(s_mask & s_flag & s_own);
endmodule

// File: rtl/dwg_checker.sv
module dwg_checker #(
  parameter int PINS = 24,
  parameter int DW   = 32,
  parameter int AW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_valid,
  input logic            bus_write,
  input logic [AW-1:0]   bus_addr,
  input logic            rsp_valid,
  input logic [DW-1:0]   rsp_rdata,
  input logic [PINS-1:0] pin_out,
  input logic [PINS-1:0] pin_oe,
  input logic            irq_priv,
  input logic            irq_sec,
  input logic [PINS-1:0] sync_q,
  input logic [PINS-1:0] s_en,
  input logic [PINS-1:0] s_lvl,
  input logic [PINS-1:0] s_flag,
  input logic [PINS-1:0] s_mask,
  input logic [PINS-1:0] s_own,
  input logic [PINS-1:0] s_out
);
  localparam logic [AW-1:0] OUT_PRIV = AW'(32);
  localparam int SEC_LAST = 6;

  logic [PINS-1:0] live;
  assign live = s_en & ~(sync_q ^ s_lvl);

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[DW-1:PINS] == '0)); // R1

  AST_NO_DRIVE_ON_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0); // R2

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(s_flag & live) & ~s_flag) == '0); // R4

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_priv || irq_sec) |-> (|(s_flag & s_mask))); // R5

  AST_OWNED_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_valid && bus_write && bus_addr == OUT_PRIV)
      |-> ((s_out ^ $past(s_out)) & $past(s_own)) == '0); // R6

  AST_SEC_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && int'($past(bus_addr[AW-1:2])) <= SEC_LAST)
      |-> (rsp_rdata[PINS-1:0] & ~s_own) == '0); // R8
endmodule

bind dual_window_gpio dwg_checker #(.PINS(PINS), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq_priv(irq_priv), .irq_sec(irq_sec),
  .sync_q(sync_q), .s_en(s_en), .s_lvl(s_lvl), .s_flag(s_flag),
  .s_mask(s_mask), .s_own(s_own), .s_out(s_out)
);

// File: tb/dual_window_gpio_bench.sv
module dual_window_gpio_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [23:0] pin_in = 24'hA5A5A5;
  logic [23:0] pin_out, pin_oe;
  logic        irq_priv, irq_sec;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dual_window_gpio u_dual_window_gpio (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_priv(irq_priv), .irq_sec(irq_sec)
  );

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    expect_eq("R9 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    expect_eq("R11 irq_priv", {31'b0, irq_priv}, 0);
    expect_eq("R11 irq_sec", {31'b0, irq_sec}, 0);
    expect_eq("R11 pin_oe", {8'b0, pin_oe}, 0);
    expect_eq("R11 bus_ready", {31'b0, bus_ready}, 1);
    rd(6'h3C, d); expect_eq("R11 owner", d, 0);
    rd(6'h1C, d); expect_eq("R11 enable", d, 0);
    rd(6'h30, d); expect_eq("R11 flag", d, 0);
  endtask

  task automatic t_width_and_drive();
    logic [31:0] d;
    wr(6'h20, 32'hFFFF_FFFF);
    rd(6'h20, d); expect_eq("R1 upper bits", d, 32'h00FF_FFFF);
    expect_eq("R2 input pins not driven", {8'b0, pin_out}, 0);
    wr(6'h24, 32'hFFFF_FFFF & 32'h0000_FFFF);
    expect_eq("R2 pin_oe", {8'b0, pin_oe}, 32'h0000_FFFF);
    expect_eq("R2 pin_out", {8'b0, pin_out}, 32'h0000_FFFF);
    wr(6'h24, 32'h0);
    expect_eq("R2 pin_out off", {8'b0, pin_out}, 0);
    rd(6'h21, d); expect_eq("R9 misaligned read", d, 0);
  endtask

  task automatic t_mirror_and_input();
    logic [31:0] d;
    pin_in = 24'h123456;
    wait_cyc(3);
    rd(6'h28, d); expect_eq("R12 in register", d, 32'h0012_3456);
    wr(6'h28, 32'h0);
    rd(6'h28, d); expect_eq("R9 in ignores write", d, 32'h0012_3456);
    rd(6'h38, d); expect_eq("R10 mirror snapshot", d, 32'h00A5_A5A5);
    wr(6'h38, 32'h0);
    rd(6'h38, d); expect_eq("R10 mirror ignores write", d, 32'h00A5_A5A5);
    rd(6'h18, d); expect_eq("R8 sec mirror unowned", d, 0);
  endtask

  task automatic t_flags();
    logic [31:0] d;
    pin_in = 24'h0;
    wait_cyc(4);
    wr(6'h2C, 32'h1);
    wr(6'h34, 32'h1);
    wr(6'h1C, 32'h007F_FFFF);
    wait_cyc(2);
    rd(6'h30, d); expect_eq("R3 active-low flags, disabled pin clear", d, 32'h007F_FFFE);
    expect_eq("R5 masked flags no irq", {31'b0, irq_priv}, 0);
    pin_in = 24'h000001;
    wait_cyc(2);
    expect_eq("R3 latency not yet", {31'b0, irq_priv}, 0);
    wait_cyc(1);
    expect_eq("R3 flag after third edge", {31'b0, irq_priv}, 1);
    expect_eq("R5 irq_sec idle", {31'b0, irq_sec}, 0);
    rd(6'h30, d); expect_eq("R3 active-high flag", d, 32'h007F_FFFF);
    wr(6'h30, 32'h00FF_FFFF);
    rd(6'h30, d); expect_eq("R4 clear while active ignored", d, 32'h007F_FFFF);
    wr(6'h3C, 32'h1);
    expect_eq("R7 irq moves off priv", {31'b0, irq_priv}, 0);
    expect_eq("R7 irq moves to sec", {31'b0, irq_sec}, 1);
    rd(6'h10, d); expect_eq("R7 sec sees flag", d, 32'h1);
    rd(6'h14, d); expect_eq("R7 sec sees mask", d, 32'h1);
    rd(6'h30, d); expect_eq("R6 priv reads owned", d, 32'h007F_FFFF);
    wr(6'h2C, 32'h00FF_FFFE);
    rd(6'h2C, d); expect_eq("R6 owned level kept", d, 32'h00FF_FFFF);
    wr(6'h30, 32'h00FF_FFFF);
    rd(6'h30, d); expect_eq("R4 idle flags clear, R6 owned kept", d, 32'h1);
    wr(6'h0C, 32'h0);
    wr(6'h10, 32'h1);
    expect_eq("R4 sec clear when idle", {31'b0, irq_sec}, 0);
    rd(6'h10, d); expect_eq("R4 sec flag zero", d, 0);
  endtask

  task automatic t_owner_windows();
    logic [31:0] d;
    wr(6'h3C, 32'h0);
    wr(6'h20, 32'hAA);
    wr(6'h24, 32'hFF);
    wr(6'h3C, 32'h0F);
    rd(6'h00, d); expect_eq("R8 sec out masked", d, 32'h0A);
    wr(6'h20, 32'h55);
    expect_eq("R6 priv write drops owned", {8'b0, pin_out}, 32'h5A);
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h20, d); expect_eq("R8 sec write drops unowned", d, 32'h5F);
    rd(6'h04, d); expect_eq("R8 sec dir masked", d, 32'h0F);
    rd(6'h08, d); expect_eq("R8 sec in masked", d, 32'h01);
    rd(6'h18, d); expect_eq("R8 sec mirror owned", d, 32'h05);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset();
    t_width_and_drive();
    t_mirror_and_input();
    t_flags();
    t_owner_windows();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule